// File: doc/BRIEF.md
# STOP-Commit I2C Register Writer

This block is a write-only I2C target that controls a bank of byte-wide control registers (19 by default, indices 0 to 18). A controller addresses it, names a starting register index, and sends any number of data bytes. Each acknowledged data byte goes into a staging copy of the register bank. The live register outputs take the staged values only when a clean STOP appears on the bus. So several registers can change together, and they never show a half-written state.

The staged data survives repeated STARTs that address other devices on the same bus. A later STOP from any of those transfers commits it. If a STOP cuts a data byte short, the block treats the transfer as corrupted: it throws away everything staged since the last commit and keeps the live outputs as they were. When bit 0 of live register 0 is set, a write to register 1 is copied to every register from 1 up to the last one. The bus lines are oversampled by the system clock. The only bus output is an open-drain pull-low request for SDA.

Top module: `i2c_commit_regs`

## Requirements
- R1: After reset, every register output reads 0x00 and `sda_pull_o` is low.
- R2: The block acknowledges an address byte only when its upper 7 bits equal `DEV_ADDR` and bit 0 (R/W) is 0. Any other address, including a read request to `DEV_ADDR`, gets no acknowledge and leaves the registers unchanged.
- R3: After the address is acknowledged, the next byte is the starting register index. The bytes after it are data, sent most significant bit first. Every byte is acknowledged, and the index advances by one after each data byte.
- R4: An acknowledged data byte does not reach `regs_o` while the transaction is still open. A STOP copies all staged bytes to `regs_o` together.
- R5: A repeated START that addresses another device does not discard staged data. The STOP that ends that other transfer commits it.
- R6: A STOP that arrives after two or more bits of a data byte have been clocked in is ignored. All data staged since the last commit is discarded, and a later STOP commits nothing until a new complete write has been received.
- R7: While bit 0 of live register 0 is 1, a data byte written to index 1 is staged into every index from 1 to `NUM_REGS`-1.
- R8: Data bytes written to an index of `NUM_REGS` or above are acknowledged and then dropped.
- R9: The acknowledge pull-low starts on the SCL falling edge that ends the eighth bit. It ends on the SCL falling edge that ends the ninth clock.
- R10: Register k appears on `regs_o[8*k+7 : 8*k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regs_o | output | 8*NUM_REGS | Live (committed) register values, register k in byte k |

## Verification
The checks assume slow bus edges relative to the system clock. Every SCL and SDA level holds for more system cycles than the synchronizer depth plus one. SDA changes while SCL is high only to signal START or STOP. The controller releases SDA during each ninth clock. The bench drives the bus with a quarter bit period of eight clock cycles and changes data only while SCL is low. It models the wired-AND line as the controller's level ANDed with the inverse of `sda_pull_o`, so that the acknowledge rising only while raw SCL is low holds by construction of the stimulus.

// File: rtl/i2c_commit_pkg.sv
package i2c_commit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK
  } fsm_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s      = scl_q[SYNC_STAGES-1];
  assign sda_s      = sda_q[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_commit_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              abort_o,
  output logic              pend_o,
  output logic              idle_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(2);

  fsm_e              state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, sub;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      sub        <= '0;
      sda_pull_o <= 1'b0;
      pend_o     <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
      if (start_i) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        // a STOP inside a data byte marks the transfer as corrupt
        if (state == ST_DATA && cnt >= MID) begin
          abort_o <= 1'b1;
          pend_o  <= 1'b0;
        end else if (pend_o) begin
          commit_o <= 1'b1;
          pend_o   <= 1'b0;
        end
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise_i && cnt < FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_i};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall_i && cnt == FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR && !shreg[0]) begin
                  state      <= ST_ADDR_ACK;
                  sda_pull_o <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                sub        <= shreg;
                state      <= ST_SUB_ACK;
                sda_pull_o <= 1'b1;
              end else begin
                wr_en_o    <= 1'b1;
                wr_idx_o   <= sub;
                wr_data_o  <= shreg;
                pend_o     <= 1'b1;
                if (sub != '1) sub <= sub + BYTE_W'(1);
                state      <= ST_DATA_ACK;
                sda_pull_o <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              state      <= (state == ST_ADDR_ACK) ? ST_SUB : ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign idle_o = (state == ST_IDLE);
endmodule

// File: rtl/commit_bank.sv
module commit_bank
  import i2c_commit_pkg::*;
#(
  parameter int NUM_REGS = 19
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          wr_idx_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic                       commit_i,
  input  logic                       abort_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [BYTE_W-1:0] live_q [NUM_REGS];
  logic [BYTE_W-1:0] hold_q [NUM_REGS];
  logic              bcast;

  // broadcast flag sampled from the committed copy
  assign bcast = wr_en_i && (wr_idx_i == BYTE_W'(1)) && live_q[0][0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic sel;
    if (g == 0) begin : g_first
      assign sel = wr_en_i && (wr_idx_i == BYTE_W'(g));
    end else begin : g_rest
      assign sel = wr_en_i && ((wr_idx_i == BYTE_W'(g)) || bcast);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[g] <= '0;
        hold_q[g] <= '0;
      end else if (commit_i) begin
        live_q[g] <= hold_q[g];
      end else if (abort_i) begin
        hold_q[g] <= live_q[g];
      end else if (sel) begin
        hold_q[g] <= wr_data_i;
      end
    end

    assign regs_o[g*BYTE_W +: BYTE_W] = live_q[g];
  end
endmodule

// File: rtl/i2c_commit_regs.sv
module i2c_commit_regs
  import i2c_commit_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1C,
  parameter int         NUM_REGS    = 19,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en, commit, abort, pend, fsm_idle;
  logic [BYTE_W-1:0] wr_idx, wr_data;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i, .rst_ni,
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .commit_o   (commit),
    .abort_o    (abort),
    .pend_o     (pend),
    .idle_o     (fsm_idle)
  );

  commit_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .abort_i   (abort),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/i2c_commit_chk.sv
module i2c_commit_chk #(
  parameter int NUM_REGS = 19
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_pull_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  commit,
  input logic                  abort,
  input logic                  pend,
  input logic                  scl_fall,
  input logic                  bus_start,
  input logic                  bus_stop,
  input logic                  fsm_idle
);
  p_regs_only_on_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(commit));

  p_commit_needs_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $past(pend));

  p_commit_abort_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && abort));

  p_no_pull_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle |-> !sda_pull_o);

  p_pull_rise_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);

  p_pull_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop)));
endmodule

bind i2c_commit_regs i2c_commit_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .regs_o     (regs_o),
  .commit     (commit),
  .abort      (abort),
  .pend       (pend),
  .scl_fall   (scl_fall),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .fsm_idle   (fsm_idle)
);

// File: tb/test_i2c_commit_regs.sv
`timescale 1ns/1ps
module test_i2c_commit_regs;
  localparam int NR = 19;
  localparam int Q  = 8;
  localparam logic [6:0] DEV = 7'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  logic sda_bus;
  logic [7:0] exp_r [NR];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_commit_regs #(.DEV_ADDR(DEV), .NUM_REGS(NR)) i_i2c_commit_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NR; k++) chk(req, regs[k*8 +: 8], exp_r[k]);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wq(Q);
      scl_m = 1'b1;   wq(2*Q);
      scl_m = 1'b0;   wq(Q);
    end
  endtask

  // sends a byte and returns whether it was acknowledged; checks ack timing (R9)
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic early;
    send_bits(b, 7);
    sda_m = b[0]; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    early = sda_pull;
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = sda_pull;
    wq(Q);
    scl_m = 1'b0; wq(Q);
    chk("R9 no pull during bit 8", {7'd0, early}, 8'h00);
    if (ack) chk("R9 release after ninth clock", {7'd0, sda_pull}, 8'h00);
  endtask

  task automatic write_regs(input logic [7:0] sub, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2, input int n);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", {7'd0, a}, 8'h01);
    send_byte(sub, a);         chk("R3 sub-address ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);      chk("R3 data ack", {7'd0, a}, 8'h01);
    end
  endtask

  task automatic t_reset();
    chk("R1 pull released", {7'd0, sda_pull}, 8'h00);
    check_regs("R1 reset value");
  endtask

  task automatic t_commit();
    i2c_start();
    write_regs(8'd3, 8'h12, 8'h34, 8'h56, 3);
    check_regs("R4 staged not visible");
    i2c_stop(); wq(4);
    exp_r[3] = 8'h12; exp_r[4] = 8'h34; exp_r[5] = 8'h56;
    check_regs("R3 R10 commit on stop");
  endtask

  task automatic t_nack();
    logic a;
    i2c_start();
    send_byte({7'h55, 1'b0}, a); chk("R2 foreign address", {7'd0, a}, 8'h00);
    send_byte(8'h01, a);         chk("R2 ignored after nack", {7'd0, a}, 8'h00);
    i2c_stop(); wq(4);
    i2c_start();
    send_byte({DEV, 1'b1}, a);   chk("R2 read request", {7'd0, a}, 8'h00);
    i2c_stop(); wq(4);
    check_regs("R2 no change");
  endtask

  task automatic t_rep_start();
    logic a;
    i2c_start();
    write_regs(8'd2, 8'hA5, 8'h00, 8'h00, 1);
    i2c_start();
    send_byte({7'h33, 1'b0}, a); chk("R5 other device", {7'd0, a}, 8'h00);
    check_regs("R5 pending kept hidden");
    i2c_stop(); wq(4);
    exp_r[2] = 8'hA5;
    check_regs("R5 later stop commits");
  endtask

  task automatic t_abort();
    i2c_start();
    write_regs(8'd7, 8'h11, 8'h00, 8'h00, 1);
    send_bits(8'hF0, 3);
    i2c_stop(); wq(4);
    check_regs("R6 mid-byte stop ignored");
    i2c_start();
    i2c_stop(); wq(4);
    check_regs("R6 discarded data stays out");
    i2c_start();
    write_regs(8'd7, 8'h22, 8'h00, 8'h00, 1);
    i2c_stop(); wq(4);
    exp_r[7] = 8'h22;
    check_regs("R6 new complete write commits");
  endtask

  task automatic t_overflow();
    i2c_start();
    write_regs(8'd18, 8'h77, 8'h88, 8'h99, 3);
    i2c_stop(); wq(4);
    exp_r[18] = 8'h77;
    check_regs("R8 out of range dropped");
  endtask

  task automatic t_bcast();
    i2c_start();
    write_regs(8'd0, 8'h01, 8'h00, 8'h00, 1);
    i2c_stop(); wq(4);
    exp_r[0] = 8'h01;
    i2c_start();
    write_regs(8'd1, 8'h3C, 8'h00, 8'h00, 1);
    i2c_stop(); wq(4);
    for (int k = 1; k < NR; k++) exp_r[k] = 8'h3C;
    check_regs("R7 broadcast");
    i2c_start();
    write_regs(8'd0, 8'h00, 8'h00, 8'h00, 1);
    i2c_stop(); wq(4);
    exp_r[0] = 8'h00;
    i2c_start();
    write_regs(8'd1, 8'h5A, 8'h00, 8'h00, 1);
    i2c_stop(); wq(4);
    exp_r[1] = 8'h5A;
    check_regs("R7 single write once flag clear");
  endtask

  initial begin
    for (int k = 0; k < NR; k++) exp_r[k] = 8'h00;
    wq(5);
    t_reset();
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_commit();
    t_nack();
    t_rep_start();
    t_abort();
    t_overflow();
    t_bcast();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wq(150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule